// File: doc/BRIEF.md
# Multichannel Triggered Waveform Playback Sequencer

This block holds one waveform record in an on-chip synchronous memory and plays it out on four channels each time a start event is accepted. A start comes either from a rising edge on an external trigger pin or from an internal periodic tick. A select input chooses the source. Every accepted start yields exactly one playback sequence. Trigger events that arrive while a sequence is still running are dropped.

Three 4-bit BCD thumbwheel words shape the sequence:

- **Common delay word.** Holds every channel back by the same number of delay steps. One step is `STEP_TICKS` clock cycles.
- **Stagger word.** Adds a cumulative per-channel offset, so channel k starts k stagger units after channel 0.
- **Rate word.** Picks the increment of a per-channel phase accumulator. Each accumulator carry steps the channel to the next sample.

Each channel raises an enable flag while it replays. It emits a sample word with a one-cycle valid strobe for every sample. The downstream logic handles scaling and the DAC.

Top module: `wave_replay_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every bit of `ch_en` and `ch_valid` is 0.
- R2: When `trig_sel` = 0, a start is requested by a rising edge of `ext_trig`. When `trig_sel` = 1, `ext_trig` is ignored and a start is requested once every `INT_PERIOD` clock cycles. Successive internally triggered runs therefore begin exactly `INT_PERIOD` cycles apart.
- R3: The three BCD words are captured when a start is accepted, and later changes have no effect on that run. A word value above 9 behaves as 9.
- R4: Let D be the common delay digit, S the stagger digit and F the rate digit. Let inc = (F+1)·`INC_UNIT` and g(j) = ceil((j+1)·2^`ACC_W` / inc). Count from the clock edge that first samples `ext_trig` high. The first valid strobe of channel 0 then follows 3 + D·`STEP_TICKS` + g(0) edges later.
- R5: Channel k (0..3) runs exactly k·S·`STEP_TICKS` cycles after channel 0. Its first strobe therefore comes 3 + (D + k·S)·`STEP_TICKS` + g(0) edges after the sampling edge.
- R6: Within a channel, sample j is strobed g(j) cycles after the channel's launch. Samples leave in address order 0 .. 2^`ADDR_W`−1, one strobe per sample.
- R7: The value of sample j is (37·j + 5) mod 2^`DATA_W`. Channel k presents it on `ch_data[k*DATA_W +: DATA_W]` in the cycle where `ch_valid[k]` is 1.
- R8: `ch_valid[k]` is 1 only while `ch_en[k]` is 1. `ch_en[k]` stays high through the strobe of the last sample and is 0 in the following cycle.
- R9: A start request is accepted only when no channel is enabled and no launch is pending. Requests at other times produce no extra strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | 1 | External trigger, asynchronous, rising edge active |
| trig_sel | input | 1 | 0 selects the external trigger, 1 selects the internal periodic trigger |
| dly_all_bcd | input | 4 | BCD digit for the common start delay, in steps |
| dly_step_bcd | input | 4 | BCD digit for the per-channel stagger, in steps |
| rate_bcd | input | 4 | BCD digit selecting the playback rate |
| ch_en | output | NUM_CH | Per-channel replay-active flags |
| ch_valid | output | NUM_CH | Per-channel sample strobes |
| ch_data | output | NUM_CH*DATA_W | Packed per-channel sample words, channel k at bits k*DATA_W upward |

## Verification
Each fault in the internal state shows up at a distinct point on the ports:

- **Latched digits or elapsed-time counter.** A wrong value moves the first strobe of every later channel by whole delay steps, visible as soon as that channel starts.
- **Per-channel phase accumulator.** A fault stretches or shrinks the gaps between strobes within a few samples.
- **Read address.** A fault shows as a wrong sample word on the very next strobe.
- **Busy logic.** A fault lets a mid-run trigger through, and the extra launch appears as unexpected strobes within one common-delay interval.
- **End-of-record handling.** A fault leaves `ch_en` high, or drops it early, within one cycle of the final sample.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  // Saturate a thumbwheel digit to the BCD range 0..9.
  function automatic logic [3:0] bcd_clamp(input logic [3:0] d);
    return (d > 4'd9) ? 4'd9 : d;
  endfunction

  // Phase increment for a rate digit: (digit+1) units.
  function automatic int unsigned rate_inc(input logic [3:0] d, input int unsigned unit);
    return (32'(bcd_clamp(d)) + 32'd1) * unit;
  endfunction

  // Cycle offset, after the start, at which channel ch is launched.
  function automatic int unsigned launch_tick(input logic [3:0] d_all, input logic [3:0] d_step,
                                              input int unsigned ch, input int unsigned step);
    return (32'(d_all) + ch * 32'(d_step)) * step;
  endfunction

  // Stored waveform content for address a.
  function automatic logic [31:0] wave_word(input int unsigned a);
    return a * 32'd37 + 32'd5;
  endfunction

endpackage

// File: rtl/wrs_trigger.sv
module wrs_trigger #(
  parameter int unsigned INT_PERIOD = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_trig,
  input  logic trig_sel,
  output logic start_o
);
  localparam int IP_W = (INT_PERIOD > 2) ? $clog2(INT_PERIOD) : 2;
  localparam logic [IP_W-1:0] IP_LAST = IP_W'(INT_PERIOD - 1);

  logic [2:0]      sync_q;
  logic [IP_W-1:0] per_cnt;
  logic            ext_edge;
  logic            int_tick;

  // Two-flop synchronizer plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_trig};
  end

  assign ext_edge = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  per_cnt <= '0;
    else if (per_cnt == IP_LAST) per_cnt <= '0;
    else                         per_cnt <= per_cnt + IP_W'(1);
  end

  assign int_tick = (per_cnt == IP_LAST);
  assign start_o  = trig_sel ? int_tick : ext_edge;

  AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);                                   // R2
  AST_INT_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |=> !int_tick);                                   // R2
endmodule

// File: rtl/wrs_delay_sched.sv
module wrs_delay_sched import wrs_pkg::*; #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned STEP_TICKS = 3600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              any_en_i,
  input  logic [3:0]        dly_all_i,
  input  logic [3:0]        dly_step_i,
  input  logic [3:0]        rate_i,
  output logic [3:0]        rate_o,
  output logic [NUM_CH-1:0] launch_o
);
  localparam int unsigned MAX_T = 9 * NUM_CH * STEP_TICKS;
  localparam int          T_W   = $clog2(MAX_T + 1);

  logic           running;
  logic [T_W-1:0] elapsed;
  logic [3:0]     all_q, step_q, rate_q;
  logic           accept;
  logic [T_W-1:0] last_tick;

  // New runs only when nothing is pending and no channel is replaying.
  assign accept    = start_i && !running && !any_en_i;
  assign last_tick = T_W'(launch_tick(all_q, step_q, NUM_CH - 1, STEP_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      elapsed <= '0;
      all_q   <= '0;
      step_q  <= '0;
      rate_q  <= '0;
    end else if (accept) begin
      running <= 1'b1;
      elapsed <= '0;
      all_q   <= bcd_clamp(dly_all_i);
      step_q  <= bcd_clamp(dly_step_i);
      rate_q  <= bcd_clamp(rate_i);
    end else if (running) begin
      if (elapsed == last_tick) running <= 1'b0;
      elapsed <= elapsed + T_W'(1);
    end
  end

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_launch
      assign launch_o[k] = running &&
        (elapsed == T_W'(launch_tick(all_q, step_q, k, STEP_TICKS)));
    end
  endgenerate

  assign rate_o = rate_q;

  AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !$past(any_en_i));                      // R9
  AST_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (elapsed <= last_tick));                       // R5
  AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (all_q <= 4'd9 && step_q <= 4'd9 && rate_q <= 4'd9)); // R3
endmodule

// File: rtl/wrs_channel.sv
module wrs_channel import wrs_pkg::*; #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned INC_UNIT = 6553
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [3:0]        rate_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              en_o,
  output logic              valid_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  logic              en_q, last_q, valid_q;
  logic [ACC_W-1:0]  acc_q, inc;
  logic [ACC_W:0]    sum;
  logic [ADDR_W-1:0] addr_q;
  logic              fire;
  logic              is_last;

  assign inc     = ACC_W'(rate_inc(rate_i, INC_UNIT));
  assign sum     = {1'b0, acc_q} + {1'b0, inc};
  // A carry out of the accumulator is one playback tick.
  assign fire    = en_q && !last_q && sum[ACC_W];
  assign is_last = (addr_q == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= '0;
      addr_q  <= '0;
    end else if (launch_i) begin
      en_q    <= 1'b1;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= fire;
      if (en_q) begin
        if (last_q) begin
          en_q   <= 1'b0;
          last_q <= 1'b0;
        end else begin
          acc_q <= sum[ACC_W-1:0];
          if (fire) begin
            addr_q <= addr_q + ADDR_W'(1);
            last_q <= is_last;
          end
        end
      end
    end
  end

  assign rd_en_o   = fire;
  assign rd_addr_o = addr_q;
  assign en_o      = en_q;
  assign valid_o   = valid_q;

  AST_VALID_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> en_q);                                         // R8
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !en_q);                                       // R9
  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_last) |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R6
  AST_EN_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(valid_q));                           // R8
endmodule

// File: rtl/wrs_wave_mem.sv
module wrs_wave_mem import wrs_pkg::*; #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        rd_en,
  input  logic [NUM_PORTS*ADDR_W-1:0] rd_addr,
  output logic [NUM_PORTS*DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Record preload; host loading is handled outside this block.
  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) mem[i] = DATA_W'(wave_word(i));
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rd_data[p*DATA_W +: DATA_W] <= '0;
        else if (rd_en[p])
          rd_data[p*DATA_W +: DATA_W] <= mem[rd_addr[p*ADDR_W +: ADDR_W]];
      end
    end
  endgenerate
endmodule

// File: rtl/wave_replay_seq.sv
module wave_replay_seq import wrs_pkg::*; #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned STEP_TICKS = 3600,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned INC_UNIT   = 6553,
  parameter int unsigned INT_PERIOD = 500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_trig,
  input  logic                     trig_sel,
  input  logic [3:0]               dly_all_bcd,
  input  logic [3:0]               dly_step_bcd,
  input  logic [3:0]               rate_bcd,
  output logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH-1:0]        ch_valid,
  output logic [NUM_CH*DATA_W-1:0] ch_data
);
  // 10*INC_UNIT must stay below 2**ACC_W so the fastest rate still divides.

  logic                     start;
  logic                     any_en;
  logic [3:0]               rate_lat;
  logic [NUM_CH-1:0]        launch;
  logic [NUM_CH-1:0]        rd_en;
  logic [NUM_CH*ADDR_W-1:0] rd_addr;

  wrs_trigger #(.INT_PERIOD(INT_PERIOD)) u_trig (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .trig_sel(trig_sel), .start_o(start)
  );

  assign any_en = |ch_en;

  wrs_delay_sched #(.NUM_CH(NUM_CH), .STEP_TICKS(STEP_TICKS)) u_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start), .any_en_i(any_en),
    .dly_all_i(dly_all_bcd), .dly_step_i(dly_step_bcd), .rate_i(rate_bcd),
    .rate_o(rate_lat), .launch_o(launch)
  );

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      wrs_channel #(.ADDR_W(ADDR_W), .ACC_W(ACC_W), .INC_UNIT(INC_UNIT)) u_ch (
        .clk(clk), .rst_n(rst_n), .launch_i(launch[k]), .rate_i(rate_lat),
        .rd_en_o(rd_en[k]), .rd_addr_o(rd_addr[k*ADDR_W +: ADDR_W]),
        .en_o(ch_en[k]), .valid_o(ch_valid[k])
      );
    end
  endgenerate

  wrs_wave_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_CH)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(ch_data)
  );

  AST_ONE_LAUNCH_PER_IDLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en[0]) |-> $past(launch[0]));                     // R4
endmodule

// File: tb/wave_replay_seq_tb.sv
module wave_replay_seq_tb;
  localparam int NCH = 4, AW = 4, DW = 12, STEP = 10, ACCW = 8, UNIT = 25, IPER = 2000;
  localparam int LEN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, ext_trig = 1'b0, trig_sel = 1'b0;
  logic [3:0] dly_all = '0, dly_step = '0, rate = '0;
  logic [NCH-1:0]    ch_en, ch_valid;
  logic [NCH*DW-1:0] ch_data;

  int cyc = 0, total = 0, bad = 0;
  bit done = 0;

  typedef struct { int idx; int data; int at; } item_t;
  item_t expq [NCH][$];
  bit    last_seen [NCH];
  int    starts[$];
  bit    watch_starts = 0;

  wave_replay_seq #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .STEP_TICKS(STEP),
    .ACC_W(ACCW), .INC_UNIT(UNIT), .INT_PERIOD(IPER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .trig_sel(trig_sel),
    .dly_all_bcd(dly_all), .dly_step_bcd(dly_step), .rate_bcd(rate),
    .ch_en(ch_en), .ch_valid(ch_valid), .ch_data(ch_data));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clamp9(int d);
    return (d > 9) ? 9 : d;
  endfunction
  function automatic int strobe_gap(int f, int j);
    int inc;
    inc = (clamp9(f) + 1) * UNIT;
    return ((j + 1) * (1 << ACCW) + inc - 1) / inc;
  endfunction
  function automatic int expect_word(int j);
    return (j * 37 + 5) % (1 << DW);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Driver side: expected items for one run; c0 < 0 disables timing checks.
  task automatic push_run(int d, int s, int f, int c0);
    for (int k = 0; k < NCH; k++) begin
      for (int j = 0; j < LEN; j++) begin
        item_t it;
        it.idx  = j;
        it.data = expect_word(j);
        it.at   = (c0 < 0) ? -1 :
                  c0 + 4 + (clamp9(d) + k * clamp9(s)) * STEP + strobe_gap(f, j);
        expq[k].push_back(it);
      end
    end
  endtask

  task automatic play(logic [3:0] d, logic [3:0] s, logic [3:0] f);
    @(negedge clk);
    dly_all = d; dly_step = s; rate = f;
    ext_trig = 1'b1;
    push_run(int'(d), int'(s), int'(f), cyc);
    repeat (3) @(negedge clk);
    ext_trig = 1'b0;
  endtask

  function automatic int pending();
    int n;
    n = 0;
    for (int k = 0; k < NCH; k++) n += expq[k].size();
    return n;
  endfunction

  task automatic drain(string req);
    int n;
    n = 0;
    while (n < 6000 && (pending() != 0 || ch_en != '0)) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(pending() == 0, req, "expected strobes left unseen", pending(), 0);
    check(ch_en == '0, "R8", "enables idle after run", int'(ch_en), 0);
  endtask

  // Monitor: pops and compares as strobes appear.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        if (last_seen[k]) begin
          check(ch_en[k] == 1'b0, "R8", "enable one cycle after last sample", int'(ch_en[k]), 0);
          last_seen[k] = 0;
        end
        if (ch_valid[k]) begin
          if (expq[k].size() == 0) begin
            check(0, "R9", "unexpected strobe on channel", k, -1);
          end else begin
            item_t it;
            int    got;
            it  = expq[k].pop_front();
            got = int'(ch_data[k*DW +: DW]);
            check(got == it.data, "R7", "sample word", got, it.data);
            check(ch_en[k] == 1'b1, "R8", "enable during strobe", int'(ch_en[k]), 1);
            if (it.at >= 0)
              check(cyc == it.at, (it.idx != 0) ? "R6" : ((k == 0) ? "R4" : "R5"),
                    "strobe cycle", cyc, it.at);
            if (it.idx == LEN - 1) last_seen[k] = 1;
            if (k == 0 && it.idx == 0 && watch_starts) starts.push_back(cyc);
          end
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      check(0, "WDOG", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ch_en == '0 && ch_valid == '0, "R1", "outputs during reset",
          int'({ch_en, ch_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ch_en == '0 && ch_valid == '0, "R1", "outputs after reset",
          int'({ch_en, ch_valid}), 0);

    // Baseline: no delay, no stagger, slowest rate.
    play(4'd0, 4'd0, 4'd0);
    drain("R4");
    // Common delay plus stagger at a middle rate.
    play(4'd2, 4'd1, 4'd3);
    drain("R5");
    // Wide stagger at the fastest rate.
    play(4'd1, 4'd3, 4'd9);
    drain("R6");
    // Out-of-range digits saturate to 9.
    play(4'hC, 4'hF, 4'hB);
    drain("R3");

    // Trigger and new digits during a run are ignored.
    play(4'd1, 4'd2, 4'd0);
    repeat (80) @(negedge clk);
    dly_all = 4'd0; dly_step = 4'd0; rate = 4'd9;
    ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    ext_trig = 1'b0;
    drain("R9");

    // Internal periodic trigger; an external edge is ignored in this mode.
    begin
      int n;
      watch_starts = 1;
      push_run(0, 0, 9, -1);
      push_run(0, 0, 9, -1);
      @(negedge clk);
      dly_all = 4'd0; dly_step = 4'd0; rate = 4'd9;
      trig_sel = 1'b1;
      ext_trig = 1'b1;
      repeat (3) @(negedge clk);
      ext_trig = 1'b0;
      n = 0;
      while (starts.size() < 2 && n < 6000) begin
        @(negedge clk);
        n++;
      end
      trig_sel = 1'b0;
      drain("R2");
      check(starts.size() == 2, "R2", "internal runs seen", starts.size(), 2);
      if (starts.size() == 2)
        check(starts[1] - starts[0] == IPER, "R2", "internal start period",
              starts[1] - starts[0], IPER);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule